// File: doc/BRIEF.md
# Branch and Skip Condition Evaluator

This block decides whether a conditional control transfer is taken. It handles three kinds of operation. A skip compares two register operands under one of eight condition codes. A register-test jump looks at the sign or the zero state of the A or the X register. A count-and-jump adds one to X, returns the new X value for write-back, and tests the sign of that new value.

The comparison subtracts the second operand from the first over DATA_W+1 bits. From that result it takes the zero, sign, borrow and two's-complement overflow flags. Signed comparisons come in two forms. The plain form reads the sign bit of the difference directly. The corrected form exclusive-ORs that sign bit with the overflow flag, so it gives the true signed order. Magnitude comparisons use the borrow flag. The program counter, the fetch path and the register file stay outside the block. It returns a taken flag, a write enable for X and the new X value.

The result is registered by default: one request in one cycle gives one result in the next cycle. Setting the REG_OUT parameter to 0 makes the block purely combinational.

Top module: `branch_cond_eval`

## Requirements
- R1: After reset, and in every cycle whose previous cycle had no request, res_valid, taken and x_wr_en are 0. A request (in_valid=1) gives res_valid=1 on the next rising clock edge.
- R2: Skips (op_kind=0) with cond=0 are taken when opnd_a equals opnd_b. With cond=1 they are taken when the two operands differ.
- R3: Skip cond=2 is taken when bit DATA_W-1 of (opnd_a-opnd_b) modulo 2^DATA_W is 0. Skip cond=4 is taken when that bit is 1. Overflow is ignored in both.
- R4: Skip cond=3 is taken when opnd_a >= opnd_b as two's-complement numbers. Skip cond=5 is taken when opnd_a < opnd_b as two's-complement numbers. The result stays correct when the subtraction overflows.
- R5: Skip cond=6 is taken when opnd_a >= opnd_b as unsigned numbers. Skip cond=7 is taken when opnd_a < opnd_b as unsigned numbers.
- R6: Register-test jumps (op_kind=1) on A are taken as follows: cond=0 when reg_a is non-negative, cond=1 when reg_a is negative, cond=2 when reg_a is zero, cond=3 when reg_a is nonzero.
- R7: Register-test jumps on X are taken as follows: cond=4 when reg_x is negative, cond=5 when reg_x is zero. Codes 6 and 7 are never taken.
- R8: Count-and-jump (op_kind=2) gives x_next = (reg_x+1) modulo 2^DATA_W and x_wr_en=1, whether or not the jump is taken. When cond bit 0 is 0 the jump is taken if the new X is non-negative. When cond bit 0 is 1 it is taken if the new X is negative.
- R9: x_wr_en is 1 only for count-and-jump results. Skips and register-test jumps leave x_wr_en at 0.
- R10: op_kind=3 is reserved. It gives res_valid=1 with taken=0 and x_wr_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is present in this cycle |
| op_kind | input | 2 | 0 skip, 1 register-test jump, 2 count-and-jump, 3 reserved |
| cond | input | 3 | Condition code for the selected kind |
| opnd_a | input | DATA_W | First skip operand (minuend) |
| opnd_b | input | DATA_W | Second skip operand (subtrahend) |
| reg_a | input | DATA_W | A register value for the register tests |
| reg_x | input | DATA_W | X register value for the tests and the count |
| res_valid | output | 1 | The result outputs hold a result |
| taken | output | 1 | The jump or skip is taken |
| x_wr_en | output | 1 | x_next must be written back to X |
| x_next | output | DATA_W | X plus one, from a count-and-jump |

## Verification
With the default REG_OUT=1, every result (taken, x_wr_en, x_next and res_valid) appears exactly one rising edge after the request. Each bench task drives a request on a falling edge and waits for the next rising edge. It then samples a couple of nanoseconds later and drops in_valid at the following falling edge. One idle cycle follows each result, so the bench can also check that the outputs return to zero. The checker ties each result to the request seen one cycle earlier.

// File: rtl/bce_pkg.sv
package bce_pkg;

   typedef enum logic [1:0] {
      KIND_SKIP  = 2'd0,
      KIND_JUMP  = 2'd1,
      KIND_COUNT = 2'd2,
      KIND_RSVD  = 2'd3
   } bce_kind_e;

   // skip condition codes
   localparam logic [2:0] SK_EQ      = 3'd0;
   localparam logic [2:0] SK_NE      = 3'd1;
   localparam logic [2:0] SK_GE_RAW  = 3'd2;
   localparam logic [2:0] SK_GE_COR  = 3'd3;
   localparam logic [2:0] SK_LT_RAW  = 3'd4;
   localparam logic [2:0] SK_LT_COR  = 3'd5;
   localparam logic [2:0] SK_MAG_GE  = 3'd6;
   localparam logic [2:0] SK_MAG_LT  = 3'd7;

   // register-test jump codes
   localparam logic [2:0] JT_A_NNEG  = 3'd0;
   localparam logic [2:0] JT_A_NEG   = 3'd1;
   localparam logic [2:0] JT_A_ZERO  = 3'd2;
   localparam logic [2:0] JT_A_NZ    = 3'd3;
   localparam logic [2:0] JT_X_NEG   = 3'd4;
   localparam logic [2:0] JT_X_ZERO  = 3'd5;

   typedef struct packed {
      logic zero;
      logic sign;
      logic borrow;
      logic ovf;
   } bce_flags_t;

endpackage

// File: rtl/bce_cmp.sv
module bce_cmp #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0]   lhs,
   input  logic [DATA_W-1:0]   rhs,
   output bce_pkg::bce_flags_t flags
);
   localparam int EXT_W = DATA_W + 1;
   localparam int MSB   = DATA_W - 1;

   logic [EXT_W-1:0] diff;

   always_comb begin
      diff         = {1'b0, lhs} - {1'b0, rhs};
      flags.zero   = (diff[MSB:0] == '0);
      flags.sign   = diff[MSB];
      flags.borrow = diff[DATA_W];
      flags.ovf    = (lhs[MSB] ^ rhs[MSB]) & (lhs[MSB] ^ diff[MSB]);
   end
endmodule

// File: rtl/bce_skip_sel.sv
module bce_skip_sel (
   input  logic [2:0]          cond,
   input  bce_pkg::bce_flags_t flags,
   output logic                take
);
   import bce_pkg::*;

   logic true_lt;

   always_comb begin
      true_lt = flags.sign ^ flags.ovf;
      unique case (cond)
         SK_EQ:     take = flags.zero;
         SK_NE:     take = ~flags.zero;
         SK_GE_RAW: take = ~flags.sign;
         SK_GE_COR: take = ~true_lt;
         SK_LT_RAW: take = flags.sign;
         SK_LT_COR: take = true_lt;
         SK_MAG_GE: take = ~flags.borrow;
         default:   take = flags.borrow;
      endcase
   end
endmodule

// File: rtl/bce_jump_sel.sv
module bce_jump_sel #(
   parameter int DATA_W = 16
) (
   input  logic [2:0]        cond,
   input  logic              count_mode,
   input  logic [DATA_W-1:0] reg_a,
   input  logic [DATA_W-1:0] reg_x,
   output logic              take,
   output logic [DATA_W-1:0] x_inc
);
   import bce_pkg::*;

   localparam int MSB = DATA_W - 1;
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic test_take;
   logic count_take;

   always_comb begin
      x_inc = reg_x + ONE;
      count_take = cond[0] ? x_inc[MSB] : ~x_inc[MSB];
      unique case (cond)
         JT_A_NNEG: test_take = ~reg_a[MSB];
         JT_A_NEG:  test_take = reg_a[MSB];
         JT_A_ZERO: test_take = (reg_a == '0);
         JT_A_NZ:   test_take = (reg_a != '0);
         JT_X_NEG:  test_take = reg_x[MSB];
         JT_X_ZERO: test_take = (reg_x == '0);
         default:   test_take = 1'b0;
      endcase
      take = count_mode ? count_take : test_take;
   end
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval #(
   parameter int DATA_W  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        op_kind,
   input  logic [2:0]        cond,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] reg_a,
   input  logic [DATA_W-1:0] reg_x,
   output logic              res_valid,
   output logic              taken,
   output logic              x_wr_en,
   output logic [DATA_W-1:0] x_next
);
   import bce_pkg::*;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("branch_cond_eval: DATA_W must be at least 2");
      end
   endgenerate

   bce_kind_e   kind;
   bce_flags_t  cmp_flags;
   logic        skip_take;
   logic        jump_take;
   logic [DATA_W-1:0] x_inc;

   logic              nx_valid;
   logic              nx_taken;
   logic              nx_wr;
   logic [DATA_W-1:0] nx_x;

   assign kind = bce_kind_e'(op_kind);

   bce_cmp #(.DATA_W(DATA_W)) u_cmp (
      .lhs   (opnd_a),
      .rhs   (opnd_b),
      .flags (cmp_flags)
   );

   bce_skip_sel u_skip (
      .cond  (cond),
      .flags (cmp_flags),
      .take  (skip_take)
   );

   bce_jump_sel #(.DATA_W(DATA_W)) u_jump (
      .cond       (cond),
      .count_mode (kind == KIND_COUNT),
      .reg_a      (reg_a),
      .reg_x      (reg_x),
      .take       (jump_take),
      .x_inc      (x_inc)
   );

   always_comb begin
      nx_valid = in_valid;
      nx_taken = 1'b0;
      nx_wr    = 1'b0;
      nx_x     = '0;
      if (in_valid) begin
         unique case (kind)
            KIND_SKIP:  nx_taken = skip_take;
            KIND_JUMP:  nx_taken = jump_take;
            KIND_COUNT: begin
               nx_taken = jump_take;
               nx_wr    = 1'b1;
               nx_x     = x_inc;
            end
            default:    nx_taken = 1'b0;
         endcase
      end
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               res_valid <= 1'b0;
               taken     <= 1'b0;
               x_wr_en   <= 1'b0;
               x_next    <= '0;
            end else begin
               res_valid <= nx_valid;
               taken     <= nx_taken;
               x_wr_en   <= nx_wr;
               x_next    <= nx_x;
            end
         end
      end else begin : g_comb
         always_comb begin
            res_valid = nx_valid;
            taken     = nx_taken;
            x_wr_en   = nx_wr;
            x_next    = nx_x;
         end
      end
   endgenerate
endmodule

// File: rtl/branch_cond_eval_chk.sv
module branch_cond_eval_chk #(
   parameter int DATA_W  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        op_kind,
   input logic [2:0]        cond,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic [DATA_W-1:0] reg_a,
   input logic [DATA_W-1:0] reg_x,
   input logic              res_valid,
   input logic              taken,
   input logic              x_wr_en,
   input logic [DATA_W-1:0] x_next
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   generate
      if (REG_OUT) begin : g_seq
         p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> res_valid);
         p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!res_valid && !taken && !x_wr_en));
         p_eq_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op_kind == 2'd0 && cond == 3'd0 && opnd_a == opnd_b) |=> taken);
         p_true_signed_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op_kind == 2'd0 && cond == 3'd5)
               |=> (taken == ($signed($past(opnd_a)) < $signed($past(opnd_b)))));
         p_mag_lt_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op_kind == 2'd0 && cond == 3'd7)
               |=> (taken == ($past(opnd_a) < $past(opnd_b))));
         p_a_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op_kind == 2'd1 && cond == 3'd2 && reg_a == '0) |=> taken);
         p_count_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op_kind == 2'd2) |=> (x_wr_en && x_next == $past(reg_x) + ONE));
         p_wr_only_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op_kind != 2'd2) |=> !x_wr_en);
         p_rsvd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op_kind == 2'd3) |=> (!taken && !x_wr_en));
      end else begin : g_comb
         always_comb begin
            if (rst_n) begin
               a_valid_r1: assert (res_valid == in_valid);
               a_wr_only_count_r9: assert (!x_wr_en || op_kind == 2'd2);
               a_count_write_r8: assert (!(in_valid && op_kind == 2'd2) || x_next == reg_x + ONE);
               a_rsvd_quiet_r10: assert (!(in_valid && op_kind == 2'd3) || !taken);
            end
         end
      end
   endgenerate
endmodule

bind branch_cond_eval branch_cond_eval_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_kind   (op_kind),
   .cond      (cond),
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .reg_a     (reg_a),
   .reg_x     (reg_x),
   .res_valid (res_valid),
   .taken     (taken),
   .x_wr_en   (x_wr_en),
   .x_next    (x_next)
);

// File: tb/test_branch_cond_eval.sv
module test_branch_cond_eval;
   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    op_kind = '0;
   logic [2:0]    cond = '0;
   logic [W-1:0]  opnd_a = '0, opnd_b = '0, reg_a = '0, reg_x = '0;
   logic          res_valid, taken, x_wr_en;
   logic [W-1:0]  x_next;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   branch_cond_eval #(.DATA_W(W), .REG_OUT(1'b1)) i_branch_cond_eval (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_kind(op_kind), .cond(cond),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .reg_a(reg_a), .reg_x(reg_x),
      .res_valid(res_valid), .taken(taken), .x_wr_en(x_wr_en), .x_next(x_next));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive one request, sample one cycle later, then one idle cycle
   task automatic issue(input logic [1:0] k, input logic [2:0] c,
                        input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] ra, input logic [W-1:0] rx,
                        input logic exp_tk, input logic exp_we,
                        input logic [W-1:0] exp_x, input string tag);
      @(negedge clk);
      in_valid = 1'b1; op_kind = k; cond = c;
      opnd_a = a; opnd_b = b; reg_a = ra; reg_x = rx;
      @(posedge clk); #2;
      check({tag, " valid"}, {31'd0, res_valid}, 32'd1);
      check({tag, " taken"}, {31'd0, taken}, {31'd0, exp_tk});
      check({tag, " wr"}, {31'd0, x_wr_en}, {31'd0, exp_we});
      if (exp_we) check({tag, " xnext"}, {16'd0, x_next}, {16'd0, exp_x});
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk); #2;
      check({tag, " idle R1"}, {29'd0, res_valid, taken, x_wr_en}, 32'd0);
   endtask

   task automatic skip(input logic [2:0] c, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic exp_tk, input string tag);
      issue(2'd0, c, a, b, '0, '0, exp_tk, 1'b0, '0, tag);
   endtask

   task automatic t_reset;
      #1;
      check("R1 reset", {29'd0, res_valid, taken, x_wr_en}, 32'd0);
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #2;
      check("R1 no request", {29'd0, res_valid, taken, x_wr_en}, 32'd0);
   endtask

   task automatic t_eq_ne;
      skip(3'd0, 16'h1234, 16'h1234, 1'b1, "R2 eq same");
      skip(3'd0, 16'h1234, 16'h1235, 1'b0, "R2 eq diff");
      skip(3'd1, 16'h0000, 16'hffff, 1'b1, "R2 ne diff");
      skip(3'd1, 16'h8000, 16'h8000, 1'b0, "R2 ne same");
   endtask

   task automatic t_signed_raw;
      // 7fff - 8000 = ffff: raw sign set although 7fff > 8000 signed
      skip(3'd2, 16'h7fff, 16'h8000, 1'b0, "R3 ge raw ovf");
      skip(3'd4, 16'h7fff, 16'h8000, 1'b1, "R3 lt raw ovf");
      skip(3'd2, 16'h0005, 16'h0003, 1'b1, "R3 ge raw plain");
      skip(3'd4, 16'h0003, 16'h0005, 1'b1, "R3 lt raw plain");
   endtask

   task automatic t_signed_cor;
      skip(3'd3, 16'h7fff, 16'h8000, 1'b1, "R4 ge cor ovf");
      skip(3'd5, 16'h7fff, 16'h8000, 1'b0, "R4 lt cor ovf");
      skip(3'd5, 16'h8000, 16'h0001, 1'b1, "R4 lt cor neg");
      skip(3'd3, 16'hfffe, 16'hfffe, 1'b1, "R4 ge cor equal");
   endtask

   task automatic t_magnitude;
      skip(3'd6, 16'h8000, 16'h7fff, 1'b1, "R5 mag ge");
      skip(3'd7, 16'h8000, 16'h7fff, 1'b0, "R5 mag lt no");
      skip(3'd7, 16'h0001, 16'hffff, 1'b1, "R5 mag lt");
      skip(3'd6, 16'h4444, 16'h4444, 1'b1, "R5 mag ge equal");
   endtask

   task automatic t_a_tests;
      issue(2'd1, 3'd0, '0, '0, 16'h0000, '0, 1'b1, 1'b0, '0, "R6 a nonneg zero");
      issue(2'd1, 3'd1, '0, '0, 16'h8000, '0, 1'b1, 1'b0, '0, "R6 a neg");
      issue(2'd1, 3'd2, '0, '0, 16'h0001, '0, 1'b0, 1'b0, '0, "R6 a zero no");
      issue(2'd1, 3'd3, '0, '0, 16'h0001, '0, 1'b1, 1'b0, '0, "R6 a nz");
   endtask

   task automatic t_x_tests;
      issue(2'd1, 3'd4, '0, '0, '0, 16'hffff, 1'b1, 1'b0, '0, "R7 x neg");
      issue(2'd1, 3'd5, '0, '0, '0, 16'h0000, 1'b1, 1'b0, '0, "R7 x zero");
      issue(2'd1, 3'd5, '0, '0, '0, 16'h0010, 1'b0, 1'b0, '0, "R7 x zero no");
      issue(2'd1, 3'd6, '0, '0, 16'h0000, 16'h0000, 1'b0, 1'b0, '0, "R7 code6 never");
      issue(2'd1, 3'd7, '0, '0, 16'hffff, 16'hffff, 1'b0, 1'b0, '0, "R7 code7 never");
   endtask

   task automatic t_count;
      issue(2'd2, 3'd0, '0, '0, '0, 16'hffff, 1'b1, 1'b1, 16'h0000, "R8 cnt wrap nonneg");
      issue(2'd2, 3'd1, '0, '0, '0, 16'hffff, 1'b0, 1'b1, 16'h0000, "R8 cnt wrap neg no");
      issue(2'd2, 3'd1, '0, '0, '0, 16'h7fff, 1'b1, 1'b1, 16'h8000, "R8 cnt to neg");
      issue(2'd2, 3'd0, '0, '0, '0, 16'hfffd, 1'b0, 1'b1, 16'hfffe, "R8 cnt not taken");
   endtask

   task automatic t_no_write;
      issue(2'd0, 3'd0, 16'h0001, 16'h0001, '0, 16'h1111, 1'b1, 1'b0, '0, "R9 skip no wr");
      issue(2'd1, 3'd4, '0, '0, '0, 16'hffff, 1'b1, 1'b0, '0, "R9 jump no wr");
   endtask

   task automatic t_reserved;
      issue(2'd3, 3'd0, 16'h0001, 16'h0001, 16'h0000, 16'h0000, 1'b0, 1'b0, '0, "R10 rsvd 0");
      issue(2'd3, 3'd1, 16'h0001, 16'h0002, 16'h8000, 16'hffff, 1'b0, 1'b0, '0, "R10 rsvd 1");
   endtask

   initial begin
      t_reset();
      t_eq_ne();
      t_signed_raw();
      t_signed_cor();
      t_magnitude();
      t_a_tests();
      t_x_tests();
      t_count();
      t_no_write();
      t_reserved();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end
endmodule